// File: doc/BRIEF.md
# Late-Arrival Correcting Pipeline Register

This block is a pipeline register of parametric width for a datapath with combinational logic in front of it. It recovers from data that settles too late for the main clock edge, without stalling the clock. Every bit holds three flops. The main flop samples on `clk`. The delay flop samples the same input on `clkd`, a clock of the same frequency whose rising edge comes later in the period. The third flop, a correction flop, is normally idle. A bit whose main and delay flops disagree raises a mismatch. All mismatches of the word are ORed together into one stage error.

A small controller sits above the bit cells. It has two states:

- `ST_PASS`: normal operation. The output shows the main flops. A detected mismatch marks the word being presented as invalid, loads the correction flops from the delay flops, and takes the transition `PASS_TO_MEND`.
- `ST_MEND`: lasts exactly one cycle. The output shows the correction flops with the validity of the faulty word. The controller then takes the transition `MEND_TO_PASS` unconditionally. The self-loop `PASS_HOLD` covers the error-free case.

Validity is active low. A downstream stage reads `inval_out` = 0 as valid data. The word captured on the edge that starts the mend cycle is overwritten by the corrected word and is never presented. A mismatch on that hidden word is ignored.

Top module: `late_fix_stage`

## Requirements
- R1: While `rst_n` is low and after it returns high, before any data is clocked, `q_out` is all zeros and `inval_out` is 1 (invalid).
- R2: In `ST_PASS` with no mismatch, the word and the invalid flag sampled at a `clk` edge appear on `q_out` and `inval_out` during the following cycle. `inval_out` = 1 means invalid and 0 means valid, and an incoming 1 is always passed on as 1.
- R3: If any bit's main flop differs from its delay flop in `ST_PASS`, `inval_out` is 1 for that cycle, whatever `inval_in` was.
- R4: In the cycle after such a mismatch, `q_out` equals the whole word taken by the delay flops. This holds for the bits that matched as well as for those that did not. The correction flops load only at that edge and hold their value at every other edge.
- R5: During the mend cycle, `inval_out` equals the invalid flag that arrived with the faulty word.
- R6: The mend state lasts exactly one cycle. The word captured on the edge that enters it is dropped, and a mismatch on that word does not extend or repeat the mend. The next word is presented normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| clkd | input | 1 | Same-frequency clock with a later rising edge, used by the delay flops |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_in | input | WIDTH | Data from the upstream combinational logic |
| inval_in | input | 1 | Upstream invalid flag (1 = invalid) |
| q_out | output | WIDTH | Stage output word |
| inval_out | output | 1 | Invalid flag to the downstream stage (1 = invalid) |

## Verification
The bench injects late transitions that land between the `clk` and `clkd` edges. It uses a single low bit, the top bit alone and the whole word. A design that compared only part of the word would miss the single-bit cases. A design that corrected only the flipped bits would fail the whole-word comparison in the mend cycle. Faulty words are sent with the upstream flag both set and clear. A controller that forgot the held flag would report the corrected word as valid when it was not. Back-to-back late words check that the word hidden behind a mend is dropped and its own mismatch is ignored. A controller that re-entered the mend state, or let the hidden word leak out, would shift every later comparison by one cycle.

// File: rtl/late_fix_pkg.sv
package late_fix_pkg;

    // Stage controller states
    typedef enum logic {
        ST_PASS = 1'b0,
        ST_MEND = 1'b1
    } fix_state_t;

endpackage

// File: rtl/late_fix_cell.sv
module late_fix_cell (
    input  logic clk,
    input  logic clkd,
    input  logic rst_n,
    input  logic d,
    input  logic sel_fix,
    input  logic sel_out,
    input  logic buf_en,
    output logic q,
    output logic dly_q,
    output logic mism
);

    logic main_q;
    logic buf_q;
    logic buf_d;

    // main flop: sampled on the nominal edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q <= 1'b0;
        end else begin
            main_q <= d;
        end
    end

    // delay flop: sampled on the late edge
    always_ff @(posedge clkd or negedge rst_n) begin
        if (!rst_n) begin
            dly_q <= 1'b0;
        end else begin
            dly_q <= d;
        end
    end

    // input select of the correction flop
    always_comb begin
        buf_d = sel_fix ? dly_q : main_q;
    end

    // correction flop: loads only when enabled by the controller
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q <= 1'b0;
        end else if (buf_en) begin
            buf_q <= buf_d;
        end
    end

    always_comb begin
        q    = sel_out ? buf_q : main_q;
        mism = main_q ^ dly_q;
    end

    // R4
    buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_en |=> $stable(buf_q));

endmodule

// File: rtl/late_fix_ormerge.sv
module late_fix_ormerge #(
    parameter int N = 16
) (
    input  logic [N-1:0] bits,
    output logic         any
);

    logic [N-1:0] acc;

    assign acc[0] = bits[0];

    generate
        for (genvar i = 1; i < N; i++) begin : g_chain
            assign acc[i] = acc[i-1] | bits[i];
        end
    endgenerate

    assign any = acc[N-1];

endmodule

// File: rtl/late_fix_ctrl.sv
module late_fix_ctrl
    import late_fix_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err_any,
    input  logic inval_in,
    output logic sel_fix,
    output logic sel_out,
    output logic buf_en,
    output logic inval_out
);

    fix_state_t st;
    fix_state_t st_nxt;
    logic       inval_q;
    logic       inval_hold;
    logic       take_err;

    assign take_err = (st == ST_PASS) && err_any;

    // next-state logic
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_PASS: st_nxt = err_any ? ST_MEND : ST_PASS;  // PASS_TO_MEND / PASS_HOLD
            ST_MEND: st_nxt = ST_PASS;                      // MEND_TO_PASS
            default: st_nxt = ST_PASS;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_PASS;
        end else begin
            st <= st_nxt;
        end
    end

    // invalid flag pipeline and hold for the mend cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inval_q    <= 1'b1;
            inval_hold <= 1'b1;
        end else begin
            inval_q <= inval_in;
            if (take_err) begin
                inval_hold <= inval_q;
            end
        end
    end

    // output logic
    always_comb begin
        sel_fix   = 1'b0;
        sel_out   = 1'b0;
        buf_en    = 1'b0;
        inval_out = 1'b1;
        unique case (st)
            ST_PASS: begin
                sel_fix   = err_any;
                buf_en    = err_any;
                sel_out   = 1'b0;
                inval_out = inval_q | err_any;
            end
            ST_MEND: begin
                sel_fix   = 1'b0;
                buf_en    = 1'b0;
                sel_out   = 1'b1;
                inval_out = inval_hold;
            end
            default: begin
                sel_fix   = 1'b0;
                sel_out   = 1'b0;
                buf_en    = 1'b0;
                inval_out = 1'b1;
            end
        endcase
    end

    // R6
    mend_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_MEND) |=> (st == ST_PASS));

    // R6
    mend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_err |=> (st == ST_MEND));

    // R5
    mend_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_err |=> (inval_out == $past(inval_q)));

    // R2
    inval_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_in && !take_err) |=> inval_out);

endmodule

// File: rtl/late_fix_stage.sv
module late_fix_stage #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             clkd,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    input  logic             inval_in,
    output logic [WIDTH-1:0] q_out,
    output logic             inval_out
);

    logic [WIDTH-1:0] mism_bus;
    logic [WIDTH-1:0] dly_bus;
    logic             err_any;
    logic             sel_fix;
    logic             sel_out;
    logic             buf_en;

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            late_fix_cell u_cell (
                .clk     (clk),
                .clkd    (clkd),
                .rst_n   (rst_n),
                .d       (d_in[b]),
                .sel_fix (sel_fix),
                .sel_out (sel_out),
                .buf_en  (buf_en),
                .q       (q_out[b]),
                .dly_q   (dly_bus[b]),
                .mism    (mism_bus[b])
            );
        end
    endgenerate

    late_fix_ormerge #(.N(WIDTH)) u_merge (
        .bits (mism_bus),
        .any  (err_any)
    );

    late_fix_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .err_any   (err_any),
        .inval_in  (inval_in),
        .sel_fix   (sel_fix),
        .sel_out   (sel_out),
        .buf_en    (buf_en),
        .inval_out (inval_out)
    );

    // R4
    fix_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && !sel_out) |=> (q_out == $past(dly_bus)));

    // R3
    err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_any && !sel_out) |=> $past(inval_out));

endmodule

// File: tb/late_fix_stage_bench.sv
module late_fix_stage_bench;

    localparam int W          = 16;
    localparam int CLK_PERIOD = 10;
    localparam int CLKD_LAG   = 6;
    localparam int WATCHDOG   = 200000;

    typedef struct {
        logic [W-1:0] val;
        logic         inv;
        logic         dc;
        string        req;
    } exp_t;

    logic         clk;
    logic         clkd;
    logic         rst_n;
    logic [W-1:0] d_in;
    logic         inval_in;
    logic [W-1:0] q_out;
    logic         inval_out;

    int   n_checks;
    int   n_fail;
    logic drop_next;
    logic after_drop;
    exp_t q_exp[$];

    late_fix_stage #(.WIDTH(W)) u_late_fix_stage (
        .clk       (clk),
        .clkd      (clkd),
        .rst_n     (rst_n),
        .d_in      (d_in),
        .inval_in  (inval_in),
        .q_out     (q_out),
        .inval_out (inval_out)
    );

    initial begin
        clk = 1'b0;
        forever #(CLK_PERIOD/2) clk = ~clk;
    end

    initial begin
        clkd = 1'b0;
        #(CLK_PERIOD/2 + CLKD_LAG);
        forever begin
            clkd = 1'b1;
            #(CLK_PERIOD/2);
            clkd = 1'b0;
            #(CLK_PERIOD/2);
        end
    end

    task automatic push_exp(input logic [W-1:0] v, input logic i, input logic dc, input string r);
        exp_t e;
        e.val = v;
        e.inv = i;
        e.dc  = dc;
        e.req = r;
        q_exp.push_back(e);
    endtask

    // called 7 time units after a clk edge; returns 7 units after the next one
    task automatic drive(input logic [W-1:0] val, input logic [W-1:0] mask, input logic inv);
        d_in     = val ^ mask;
        inval_in = inv;
        @(posedge clk);
        #3;
        d_in = val;
        #4;
        if (drop_next) begin
            drop_next  = 1'b0;
            after_drop = 1'b1;
        end else if (mask != '0) begin
            push_exp('0, 1'b1, 1'b1, "R3");
            push_exp(val, inv, 1'b0, inv ? "R5" : "R4");
            drop_next = 1'b1;
        end else begin
            push_exp(val, inv, 1'b0, after_drop ? "R6" : "R2");
            after_drop = 1'b0;
        end
    endtask

    // monitor: pops one expectation per cycle, sampled late in the cycle
    initial begin
        forever begin
            @(posedge clk);
            #9;
            if (q_exp.size() > 0) begin
                automatic exp_t e = q_exp.pop_front();
                n_checks++;
                if (e.dc) begin
                    if (inval_out !== 1'b1) begin
                        n_fail++;
                        $display("FAIL %s: inval_out=%b expected 1 on faulty word", e.req, inval_out);
                    end
                end else if (q_out !== e.val || inval_out !== e.inv) begin
                    n_fail++;
                    $display("FAIL %s: q_out=%h inval_out=%b expected %h/%b",
                             e.req, q_out, inval_out, e.val, e.inv);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD*WATCHDOG);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        n_checks   = 0;
        n_fail     = 0;
        drop_next  = 1'b0;
        after_drop = 1'b0;
        rst_n      = 1'b0;
        d_in       = '0;
        inval_in   = 1'b1;

        repeat (3) @(posedge clk);
        #9;
        n_checks++;  // R1 during reset
        if (q_out !== '0 || inval_out !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: q_out=%h inval_out=%b expected 0000/1 in reset", q_out, inval_out);
        end
        @(posedge clk);
        #2;
        rst_n = 1'b1;
        #7;
        n_checks++;  // R1 after release
        if (q_out !== '0 || inval_out !== 1'b1) begin
            n_fail++;
            $display("FAIL R1: q_out=%h inval_out=%b expected 0000/1 after reset", q_out, inval_out);
        end

        @(posedge clk);
        #7;
        // R2: clean words with alternating validity
        for (int k = 0; k < 8; k++) begin
            drive(W'(16'h1111 * (k + 1)), '0, logic'(k % 2));
        end
        // R3/R4: single low bit late, valid word
        drive(16'hA5A5, 16'h0001, 1'b0);
        drive(16'h0F0F, '0, 1'b0);   // dropped
        drive(16'h1234, '0, 1'b0);   // R6
        drive(16'h5678, '0, 1'b0);
        // R5: top bit late on an invalid word
        drive(16'hC3C3, 16'h8000, 1'b1);
        drive(16'h7777, '0, 1'b0);   // dropped
        drive(16'h2468, '0, 1'b1);
        // R6: whole word late, next word also late (ignored)
        drive(16'h9ABC, 16'hFFFF, 1'b0);
        drive(16'hDEAD, 16'h0F00, 1'b0);
        drive(16'hBEEF, '0, 1'b0);
        // back-to-back faults separated by one hidden word
        drive(16'h0101, 16'h0100, 1'b0);
        drive(16'h3333, '0, 1'b1);
        drive(16'hFACE, 16'h0081, 1'b1);
        drive(16'h4444, '0, 1'b0);
        drive(16'h8001, '0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            drive(W'(16'h0F00 + k), '0, 1'b0);
        end

        repeat (3) @(posedge clk);
        #9;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule